// File: doc/BRIEF.md
# Serial Bus Hold Pause Controller

This block is the pause logic that sits in front of the receive and transmit
shifters of a serial peripheral slave. The bus master can use an active-low
pause input to suspend a transfer mid-byte without releasing the select line.
The block samples select, pause and serial clock into its own clock domain. It
aligns the start and end of a pause with the serial clock being low. From this
it drives a pause flag, an active-low output-driver enable and a qualified
shift strobe, one pulse per usable serial clock rising edge.

A pause edge that arrives while the serial clock is high takes effect only when
the clock next drops. While the block is paused the output driver is released
and the shift strobe is suppressed, so the shifters keep their bit position and
partial byte. The transfer then continues at the next bit. If the select line
is released during a pause, the block holds the serial interface in reset. It
lets communication resume only after the pause input goes high first and a
fresh select falling edge follows. Program, erase or status-write cycles that
are already running do not pass through this block.

There is no data stream at this boundary. All pins are plain level controls,
so no valid/ready handshake applies and there is no back-pressure.

Top module: `spi_hold_pause`

## Requirements
- R1: With select high (cs_n=1), a low pause input never raises hold_active.
- R2: When pause (hold_n=0) is seen while selected and the serial clock is low, hold_active rises.
- R3: When pause falls while the serial clock is high, hold_active stays 0 until the clock goes low, then rises.
- R4: When pause returns high while the clock is low, hold_active falls. If the clock is high at that point, it falls once the clock next goes low.
- R5: While hold_active is 1, out_en_n is 1 and serial clock toggles produce no shift_en pulse.
- R6: In the running state with select low, each serial clock rising edge gives exactly one shift_en pulse. The pulse count continues across a pause, so no bit is lost or added.
- R7: Select going high during a pause drops hold_active and raises if_reset, with out_en_n at 1.
- R8: if_reset stays 1, with no hold and no shift pulses, until pause is high together with select high and select is then driven low. Lowering select before raising pause does not end it.
- R9: In reset and after it (select high, pause high), hold_active=0, if_reset=0 and out_en_n=1. Asserting rst_n low during a pause clears hold_active.
- R10: When selected and neither paused nor in interface reset, out_en_n is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock that samples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low select from the master |
| hold_n | input | 1 | Active-low pause request from the master |
| sclk | input | 1 | Serial clock from the master |
| hold_active | output | 1 | 1 while the interface is paused |
| out_en_n | output | 1 | Active-low enable for the serial data output driver |
| if_reset | output | 1 | 1 while the serial interface is held in reset after a deselect during pause |
| shift_en | output | 1 | One-cycle strobe for each usable serial clock rising edge |

## Verification
The pause input is moved with the serial clock both low and high, for entry and for exit. This separates immediate entry and release from entry and release that wait for the next low clock phase. Clock toggles during a pause are compared with toggles before and after it through the strobe count. That shows the bit position is frozen rather than reset or advanced. Select is released during a pause, and then the two restart orders are applied: select first or pause first. Only the pause-first order may clear the interface reset.

// File: rtl/spi_hold_pkg.sv
package spi_hold_pkg;
  typedef enum logic [1:0] {
    ST_RUN       = 2'd0,
    ST_PAUSE     = 2'd1,
    ST_LOCK_HOLD = 2'd2,
    ST_LOCK_SEL  = 2'd3
  } hold_state_e;
endpackage

// File: rtl/spi_hold_sync.sv
module spi_hold_sync #(
  parameter int          WIDTH   = 3,
  parameter int          STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  generate
    if (STAGES == 0) begin : g_bypass
      assign q = d;
    end else begin : g_chain
      logic [WIDTH-1:0] chain [STAGES];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
        end else begin
          chain[0] <= d;
          for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
      end
      assign q = chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/spi_hold_fsm.sv
module spi_hold_fsm
  import spi_hold_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cs_n,
  input  logic        hold_n,
  input  logic        sclk,
  output hold_state_e state,
  output logic        shift_en
);
  hold_state_e state_nx;
  logic        sclk_q;

  // Pause entry and exit both require the serial clock low, which defers
  // an edge seen during the high phase to the next low phase.
  always_comb begin
    state_nx = state;
    unique case (state)
      ST_RUN:       if (!cs_n && !hold_n && !sclk) state_nx = ST_PAUSE;
      ST_PAUSE:     if (cs_n)                      state_nx = ST_LOCK_HOLD;
                    else if (hold_n && !sclk)      state_nx = ST_RUN;
      ST_LOCK_HOLD: if (hold_n && cs_n)            state_nx = ST_LOCK_SEL;
      ST_LOCK_SEL:  if (!hold_n)                   state_nx = ST_LOCK_HOLD;
                    else if (!cs_n)                state_nx = ST_RUN;
      default:                                     state_nx = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_RUN;
      sclk_q <= 1'b0;
    end else begin
      state  <= state_nx;
      sclk_q <= sclk;
    end
  end

  assign shift_en = (state == ST_RUN) && !cs_n && sclk && !sclk_q;
endmodule

// File: rtl/spi_hold_pause.sv
module spi_hold_pause
  import spi_hold_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic hold_n,
  input  logic sclk,
  output logic hold_active,
  output logic out_en_n,
  output logic if_reset,
  output logic shift_en
);
  localparam int NPINS = 3;
  localparam logic [NPINS-1:0] PIN_IDLE = 3'b110; // cs_n, hold_n, sclk

  logic [NPINS-1:0] pins_s;
  logic             s_cs_n, s_hold_n, s_sclk;
  hold_state_e      state;

  spi_hold_sync #(
    .WIDTH  (NPINS),
    .STAGES (SYNC_STAGES),
    .RST_VAL(PIN_IDLE)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({cs_n, hold_n, sclk}),
    .q    (pins_s)
  );

  assign {s_cs_n, s_hold_n, s_sclk} = pins_s;

  spi_hold_fsm u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_n    (s_cs_n),
    .hold_n  (s_hold_n),
    .sclk    (s_sclk),
    .state   (state),
    .shift_en(shift_en)
  );

  assign hold_active = (state == ST_PAUSE);
  assign if_reset    = (state == ST_LOCK_HOLD) || (state == ST_LOCK_SEL);
  assign out_en_n    = s_cs_n || (state != ST_RUN);
endmodule

// File: rtl/spi_hold_pause_chk.sv
module spi_hold_pause_chk (
  input logic clk,
  input logic rst_n,
  input logic s_cs_n,
  input logic s_hold_n,
  input logic s_sclk,
  input logic hold_active,
  input logic out_en_n,
  input logic if_reset,
  input logic shift_en
);
  a_r1_entry_only_selected: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_active) |-> $past(!s_cs_n));

  a_r2_entry_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_active) |-> $past(!s_sclk && !s_hold_n));

  a_r4_exit_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(hold_active) && !if_reset) |-> $past(s_hold_n && !s_sclk));

  a_r5_paused_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    hold_active |-> (out_en_n && !shift_en));

  a_r7_deselect_resets: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_active && s_cs_n) |=> (if_reset && !hold_active));

  a_r8_restart_order: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(if_reset) |-> $past(s_hold_n && !s_cs_n));

  a_r8_locked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    if_reset |-> (out_en_n && !shift_en && !hold_active));
endmodule

bind spi_hold_pause spi_hold_pause_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .s_cs_n     (s_cs_n),
  .s_hold_n   (s_hold_n),
  .s_sclk     (s_sclk),
  .hold_active(hold_active),
  .out_en_n   (out_en_n),
  .if_reset   (if_reset),
  .shift_en   (shift_en)
);

// File: tb/spi_hold_pause_test.sv
module spi_hold_pause_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, hold_n = 1'b1, sclk = 1'b0;
  logic hold_active, out_en_n, if_reset, shift_en;
  int   tests = 0, fails = 0, pulses = 0;
  bit   done = 1'b0;

  always #4 clk = ~clk; // 125 MHz

  spi_hold_pause uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .hold_n(hold_n), .sclk(sclk),
    .hold_active(hold_active), .out_en_n(out_en_n), .if_reset(if_reset),
    .shift_en(shift_en)
  );

  always_ff @(posedge clk) if (shift_en) pulses <= pulses + 1;

  // {cs_n, hold_n, sclk, exp_hold, exp_oe_n, exp_rst, req[3:0]}
  localparam int NV = 18;
  localparam logic [9:0] VEC [NV] = '{
    {3'b110, 3'b010, 4'd9},  // R9 idle after reset
    {3'b010, 3'b000, 4'd10}, // R10 selected, driving
    {3'b011, 3'b000, 4'd10}, // R10 clock high
    {3'b001, 3'b000, 4'd3},  // R3 pause with clock high: deferred
    {3'b000, 3'b110, 4'd3},  // R3 clock low: pause starts
    {3'b001, 3'b110, 4'd5},  // R5 clock toggles ignored
    {3'b011, 3'b110, 4'd4},  // R4 release with clock high: deferred
    {3'b010, 3'b000, 4'd4},  // R4 clock low: pause ends
    {3'b000, 3'b110, 4'd2},  // R2 pause with clock low: immediate
    {3'b010, 3'b000, 4'd4},  // R4 release with clock low: immediate
    {3'b100, 3'b010, 4'd1},  // R1 deselected: no pause
    {3'b000, 3'b110, 4'd2},  // R2 select with pause low
    {3'b100, 3'b011, 4'd7},  // R7 deselect during pause
    {3'b000, 3'b011, 4'd8},  // R8 select before pause release
    {3'b010, 3'b011, 4'd8},  // R8 pause high while selected: still locked
    {3'b110, 3'b011, 4'd8},  // R8 pause high, deselected
    {3'b010, 3'b000, 4'd8},  // R8 select after pause high: restart
    {3'b110, 3'b010, 4'd9}   // R9 idle again
  };

  task automatic settle();
    repeat (6) @(posedge clk);
    #2;
  endtask

  task automatic check(input string req, input logic [2:0] got, input logic [2:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: {hold,oe_n,rst} got %b expected %b", req, got, exp);
    end
  endtask

  task automatic toggle(input int n);
    for (int i = 0; i < n; i++) begin
      sclk = 1'b1; settle();
      sclk = 1'b0; settle();
    end
  endtask

  task automatic check_cnt(input string req, input int got, input int exp);
    tests++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: shift pulses got %0d expected %0d", req, got, exp);
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int base;
    repeat (3) @(posedge clk);
    #2;
    check("R9 in reset", {hold_active, out_en_n, if_reset}, 3'b010);
    rst_n = 1'b1;
    settle();

    for (int v = 0; v < NV; v++) begin
      {cs_n, hold_n, sclk} = VEC[v][9:7];
      settle();
      check($sformatf("R%0d row %0d", VEC[v][3:0], v),
            {hold_active, out_en_n, if_reset}, VEC[v][6:4]);
    end

    // R6 / R5: bit position frozen across a pause
    cs_n = 1'b0; sclk = 1'b0; hold_n = 1'b1; settle();
    base = pulses;
    toggle(3);
    check_cnt("R6 before pause", pulses - base, 3);
    hold_n = 1'b0; settle();
    base = pulses;
    toggle(4);
    check_cnt("R5 toggles during pause", pulses - base, 0);
    hold_n = 1'b1; settle();
    base = pulses;
    toggle(5);
    check_cnt("R6 after pause", pulses - base, 5);

    // R8: no shift pulses while locked
    hold_n = 1'b0; settle();
    cs_n = 1'b1; settle();
    cs_n = 1'b0; settle();
    base = pulses;
    toggle(2);
    check_cnt("R8 locked no shift", pulses - base, 0);
    check("R8 still locked", {hold_active, out_en_n, if_reset}, 3'b011);
    hold_n = 1'b1; cs_n = 1'b1; settle();
    cs_n = 1'b0; settle();

    // R9: reset during a pause
    hold_n = 1'b0; settle();
    check("R2 pause before reset", {hold_active, out_en_n, if_reset}, 3'b110);
    cs_n = 1'b1; hold_n = 1'b1;
    rst_n = 1'b0; #3;
    check("R9 reset clears pause", {hold_active, out_en_n, if_reset}, 3'b010);
    settle();
    rst_n = 1'b1; settle();
    check("R9 after reset", {hold_active, out_en_n, if_reset}, 3'b010);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule